// File: doc/BRIEF.md
# Clock Power Policy Engine

This block keeps four clock-enable masks, one for each operating policy, and drives the per-clock enable vector of whichever policy is active. Policies are numbered from 0 to 3, and a lower number means lower power. Software selects a new policy by writing a start command to the control register. The command either switches the active policy at once and then waits out a settle interval, or it records a target policy that is copied into the active one when the settle interval ends. The settle interval stands in for voltage ramping and is a programmable count of clock cycles.

Every register except the access key is protected. A key write unlocks the protected registers and a second key write locks them again. The masks may be edited only after the engine has been halted through its stop register. A later start command makes the engine run again.

Register words are selected by `wr_addr` and `rd_addr`:

| Word | Contents |
|------|----------|
| 0 | Access key |
| 1 | Control on write, status on read |
| 2 | Stop |
| 3 | Settle count |
| 4 to 7 | Masks for policies 0 to 3 |

Reads are combinational and always allowed.

Top module: `clk_policy_engine`

## Requirements
- R1: After reset the following hold: active and target policy are 2, the engine is locked, running and idle, every mask is all ones (so `clk_en` is all ones), and the settle count is SETTLE_INIT. Word 1 then reads 0x220.
- R2: A write to word 0 whose bits [31:1] equal 0xA5A500>>1 sets the unlock state to bit 0 of the written value. Any other value written to word 0 is ignored. Word 0 reads the unlock state in bit 0.
- R3: While the engine is locked, writes to words 1 to 7 are ignored. Reads are always allowed.
- R4: A mask write (word 4 + policy) takes effect only when the engine is unlocked and stopped. Otherwise it is ignored.
- R5: An unlocked write with bit 0 set to word 2 requests a halt, and the request reads as 1 in bit 0 of word 2. The halt completes on the first cycle in which the engine is not busy. After that, bit 0 reads 0 and bit 1 (stopped) reads 1.
- R6: A start command is an unlocked write to word 1 with bit 0 (GO) set. When it also has bit 1 (sync) set, the active policy and the target policy both become bits [5:4] at the write edge, and busy is set.
- R7: A start with bit 2 (auto-copy) set and sync clear loads only the target policy. The active policy is held while busy and takes the target value on the edge that clears busy.
- R8: A start with neither sync nor auto-copy loads the target policy and never changes the active policy.
- R9: After an accepted start, busy (word 1 bit 0) stays 1 for settle+1 cycles and then clears by itself. A write with GO clear has no effect. A start made while busy or while a halt is pending is ignored.
- R10: `clk_en` always equals the mask of the active policy. Word 1 reads active in [9:8], target in [5:4] and busy in [0].
- R11: An accepted start clears the stopped state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read word address |
| rd_data | output | 32 | Read data (combinational) |
| clk_en | output | NCLK | Clock enables of the active policy |
| active_pol | output | 2 | Active policy number |

## Verification
The properties assume that `wr_en`, `wr_addr` and `wr_data` are settled at each rising edge and are single-word writes. They also assume that a halt request and a start command never share an edge, which holds because the two live at different word addresses. The bench changes every input on the falling edge and keeps each write strobe to a single cycle. It starts busy intervals only with a known settle count, so the cycle on which busy clears and the auto-copy happens can be predicted exactly.

// File: rtl/clk_policy_engine.sv
module clk_policy_engine #(
  parameter int NCLK        = 32,
  parameter int SETTLE_W    = 16,
  parameter int SETTLE_INIT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      wr_addr,
  input  logic [31:0]     wr_data,
  input  logic [2:0]      rd_addr,
  output logic [31:0]     rd_data,
  output logic [NCLK-1:0] clk_en,
  output logic [1:0]      active_pol
);
  localparam logic [23:0] KEY      = 24'hA5A500;
  localparam logic [1:0]  POL_INIT = 2'd2;

  logic                unlocked_q, busy_q, stopped_q, stop_pend_q, copy_q;
  logic [1:0]          active_q, target_q;
  logic [SETTLE_W-1:0] settle_q, cnt_q;
  logic [NCLK-1:0]     mask_q [4];

  logic wr_ok, go_ok, stop_req, mask_ok;
  assign wr_ok    = wr_en && unlocked_q;
  assign go_ok    = wr_ok && wr_addr == 3'd1 && wr_data[0] && !busy_q && !stop_pend_q;
  assign stop_req = wr_ok && wr_addr == 3'd2 && wr_data[0] && !stopped_q && !stop_pend_q;
  assign mask_ok  = wr_ok && wr_addr[2] && stopped_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked_q <= 1'b0;
    end else if (wr_en && wr_addr == 3'd0 && wr_data[31:1] == {8'h00, KEY[23:1]}) begin
      unlocked_q <= wr_data[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_q <= SETTLE_W'(SETTLE_INIT);
    end else if (wr_ok && wr_addr == 3'd3) begin
      settle_q <= wr_data[SETTLE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) mask_q[i] <= '1;
    end else if (mask_ok) begin
      mask_q[wr_addr[1:0]] <= wr_data[NCLK-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      copy_q   <= 1'b0;
      cnt_q    <= '0;
      active_q <= POL_INIT;
      target_q <= POL_INIT;
    end else if (go_ok) begin
      busy_q   <= 1'b1;
      copy_q   <= wr_data[2] && !wr_data[1];
      cnt_q    <= settle_q;
      target_q <= wr_data[5:4];
      if (wr_data[1]) active_q <= wr_data[5:4];
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
        if (copy_q) active_q <= target_q;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stopped_q   <= 1'b0;
      stop_pend_q <= 1'b0;
    end else if (go_ok) begin
      stopped_q <= 1'b0;
    end else if (stop_req) begin
      stop_pend_q <= 1'b1;
    end else if (stop_pend_q && !busy_q) begin
      stop_pend_q <= 1'b0;
      stopped_q   <= 1'b1;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      3'd0: rd_data[0] = unlocked_q;
      3'd1: begin
        rd_data[0]   = busy_q;
        rd_data[5:4] = target_q;
        rd_data[9:8] = active_q;
      end
      3'd2: rd_data[1:0] = {stopped_q, stop_pend_q};
      3'd3: rd_data[SETTLE_W-1:0] = settle_q;
      default: rd_data[NCLK-1:0] = mask_q[rd_addr[1:0]];
    endcase
  end

  assign clk_en     = mask_q[active_q];
  assign active_pol = active_q;
endmodule

// File: rtl/clk_policy_engine_chk.sv
module clk_policy_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  wr_addr,
  input logic [31:0] wr_data,
  input logic        busy,
  input logic [1:0]  active,
  input logic        unlocked,
  input logic        stopped,
  input logic        stop_pend
);
  p_locked_no_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && wr_en && wr_addr == 3'd1 && !busy) |=> !busy);

  p_sync_switch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && wr_en && wr_addr == 3'd1 && wr_data[0] && wr_data[1] && !busy && !stop_pend)
      |=> (busy && active == $past(wr_data[5:4])));

  p_hold_while_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(active)));

  p_halt_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stopped) |-> !$past(busy));

  p_halt_states_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stopped, stop_pend}));
endmodule

bind clk_policy_engine clk_policy_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .busy(busy_q), .active(active_q), .unlocked(unlocked_q),
  .stopped(stopped_q), .stop_pend(stop_pend_q)
);

// File: tb/clk_policy_engine_bench.sv
module clk_policy_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [31:0] clk_en;
  logic [1:0]  active_pol;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  clk_policy_engine u_clk_policy_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .clk_en(clk_en), .active_pol(active_pol)
  );

  // {req[3:0], we, waddr[2:0], wdata[31:0], raddr[2:0], exp[31:0]}
  localparam int NV = 14;
  localparam logic [74:0] VEC [NV] = '{
    {4'd1,  1'b0, 3'd0, 32'h0,        3'd1, 32'h220},        // R1 reset status
    {4'd3,  1'b1, 3'd3, 32'h0,        3'd3, 32'd4},          // R3 locked settle write
    {4'd2,  1'b1, 3'd0, 32'hA5A501,   3'd0, 32'd1},          // R2 unlock
    {4'd2,  1'b1, 3'd0, 32'hA5A400,   3'd0, 32'd1},          // R2 bad key ignored
    {4'd3,  1'b1, 3'd3, 32'h0,        3'd3, 32'd0},          // settle = 0
    {4'd4,  1'b1, 3'd4, 32'hF,        3'd4, 32'hFFFF_FFFF},  // R4 running: mask ignored
    {4'd5,  1'b1, 3'd2, 32'h1,        3'd2, 32'd1},          // R5 halt pending
    {4'd5,  1'b0, 3'd0, 32'h0,        3'd2, 32'd2},          // R5 stopped
    {4'd4,  1'b1, 3'd4, 32'hF,        3'd4, 32'hF},          // R4 mask0
    {4'd4,  1'b1, 3'd5, 32'hFF,       3'd5, 32'hFF},         // R4 mask1
    {4'd4,  1'b1, 3'd7, 32'hF0F0,     3'd7, 32'hF0F0},       // R4 mask3
    {4'd6,  1'b1, 3'd1, 32'h13,       3'd1, 32'h111},        // R6 sync start policy 1
    {4'd9,  1'b0, 3'd0, 32'h0,        3'd1, 32'h110},        // R9 busy clears
    {4'd11, 1'b0, 3'd0, 32'h0,        3'd2, 32'd0}           // R11 start cleared stopped
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input int req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input int req);
    rd_addr = a; #1;
    chk(rd_data, exp, req);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);
    chk(clk_en, 32'hFFFF_FFFF, 1); // R1 all masks set
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][70]) wr(VEC[i][69:67], VEC[i][66:35]);
      else idle(1);
      rd(VEC[i][34:32], VEC[i][31:0], int'(VEC[i][74:71]));
    end
    chk(clk_en, 32'hFF, 10); // R10 policy 1 mask

    // R7 auto-copy with settle 3: busy for 4 cycles
    wr(3'd3, 32'd3);
    wr(3'd1, 32'h35);
    rd(3'd1, 32'h131, 7);
    idle(3);
    rd(3'd1, 32'h131, 7);
    chk(clk_en, 32'hFF, 7);
    idle(1);
    rd(3'd1, 32'h330, 7);
    chk(clk_en, 32'hF0F0, 10);
    chk({30'b0, active_pol}, 32'd3, 10);

    // R9 start while busy ignored, halt waits for idle (R5)
    wr(3'd1, 32'h03);
    wr(3'd1, 32'h23);
    rd(3'd1, 32'h001, 9);
    wr(3'd2, 32'h1);
    rd(3'd2, 32'd1, 5);
    idle(3);
    rd(3'd2, 32'd2, 5);
    chk(clk_en, 32'hF, 10);

    // R9 GO clear has no effect
    wr(3'd1, 32'h12);
    rd(3'd1, 32'h000, 9);
    rd(3'd2, 32'd2, 9);

    // R8 plain start: target moves, active never
    wr(3'd1, 32'h31);
    idle(6);
    rd(3'd1, 32'h030, 8);

    // R2 relock then R3 locked write ignored
    wr(3'd0, 32'hA5A500);
    rd(3'd0, 32'd0, 2);
    wr(3'd3, 32'd7);
    rd(3'd3, 32'd3, 3);
    wr(3'd1, 32'h13);
    rd(3'd1, 32'h030, 3);

    // R1 reset again
    @(negedge clk); rst_n = 1'b0;
    idle(1);
    rd(3'd1, 32'h220, 1);
    chk(clk_en, 32'hFFFF_FFFF, 1);
    rd(3'd3, 32'd4, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule